// File: doc/BRIEF.md
# Polled Serial Peripheral Interface Master

This block is a serial peripheral interface master that sits on a small 16-bit register bus. Software sets up the controller through a control register. That register holds an enable bit, the clock idle level, the clock phase and a 7-bit divider. Software then writes one byte to the data offset. Each accepted write runs exactly one full-duplex 8-bit exchange. The block drives the serial clock and the outgoing data line and samples the incoming data line. Chip select is not part of this block.

Software polls a status register. The busy bit shows that a byte is still being shifted. The full bit shows that a received byte waits in the data offset. Reading the data offset returns the received byte and clears the full bit. To receive without sending, software writes 0 as the outgoing byte.

The serial clock is derived from the system clock. Each half period lasts D+1 system clocks, where D is the divider field, so one exchange lasts 16·(D+1) cycles. Reads are registered: read data appears on the cycle after the read strobe.

Top module: `spi_host_ctrl`

## Requirements
- R1: The control register is at offset 2. It reads back the enable at bit 0, the phase at bit 7, the idle level at bit 8 and the divider at bits 15:9. All other bits read 0. Read data appears one cycle after the read strobe.
- R2: After reset, the control, status and data offsets read 0 and both the serial clock and the outgoing data line are low.
- R3: A write to offset 0 that is accepted sends bits 7:0 of the write data on the outgoing line, most significant bit first. A write is accepted when the enable bit is set and the block is not busy.
- R4: The incoming line is captured most significant bit first. The received byte reads back from offset 0 in bits 7:0, with the upper bits 0.
- R5: The status register is at offset 4, with bit 0 = busy and bit 1 = full. Busy is high for exactly 16·(D+1) cycles, starting at the clock edge that accepts the write. Full rises at the same edge on which busy falls.
- R6: During an exchange the serial clock toggles exactly 16 times, once every D+1 system clocks.
- R7: With phase 0, the outgoing line is valid before the first clock edge and the incoming line is sampled on leading edges. With phase 1, the outgoing line changes on leading edges and the incoming line is sampled on trailing edges. This holds for both idle levels.
- R8: A read of offset 0 clears the full bit, unless a byte completes in the same cycle.
- R9: A write to offset 0 while busy is ignored. The running exchange keeps its byte and its length.
- R10: A write to offset 0 while the enable bit is clear starts nothing and leaves the received byte unchanged.
- R11: Clearing the enable bit during an exchange drops busy one cycle after the control write. The serial clock returns to the idle level.
- R12: Outside an exchange, the serial clock rests at the configured idle level. After a change of idle level it follows within one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| spi_miso | input | 1 | Incoming serial data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Outgoing serial data |

## Verification
The checks take for granted that software changes neither the idle level nor the phase while busy is high. They also take for granted that the divider stays stable during an exchange and that the read and write strobes are single-cycle pulses. The stimulus honours this by rewriting the control register only while the block is idle, or when it clears the enable bit to abort. A reactive serial slave in the bench follows the clock edges. It shifts its own byte for every mode, divider value and data pattern in the sweep, so the received and transmitted bytes and the exchange length can each be checked against arithmetic.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 7;

  // register offsets
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 2;
  localparam int OFS_STAT = 4;

  // control bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_PHASE = 7;
  localparam int BIT_IDLE  = 8;
  localparam int DIV_LSB   = 9;

  // status bit positions
  localparam int BIT_BUSY = 0;
  localparam int BIT_FULL = 1;
endpackage

// File: rtl/spi_host_divider.sv
module spi_host_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [EDGE_W-1:0] edge_q;
  logic              busy_q, sck_q, mosi_q;
  logic              active_tick, leading, sample_now, drive_now;

  always_comb begin
    active_tick = busy_q && en && tick;
    leading     = ~edge_q[0];
    sample_now  = active_tick && (leading ^ cpha);
    drive_now   = active_tick && !(leading ^ cpha) && (edge_q != LAST_EDGE);
    done        = active_tick && (edge_q == LAST_EDGE);
    rx_word     = sample_now ? {rx_q[BYTE_W-2:0], miso} : rx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (!en) begin
        busy_q <= 1'b0;
        edge_q <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        rx_q   <= '0;
        if (!cpha) begin
          mosi_q <= tx_byte[BYTE_W-1];
          tx_q   <= tx_byte << 1;
        end else begin
          tx_q   <= tx_byte;
        end
      end else if (active_tick) begin
        edge_q <= edge_q + 1'b1;
        if (done)       busy_q <= 1'b0;
        if (sample_now) rx_q   <= rx_word;
        if (drive_now) begin
          mosi_q <= tx_q[BYTE_W-1];
          tx_q   <= tx_q << 1;
        end
      end
      if (!en || !busy_q)   sck_q <= cpol;
      else if (active_tick) sck_q <= ~sck_q;
    end
  end

  assign busy = busy_q;
  assign sck  = sck_q;
  assign mosi = mosi_q;
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_word,
  output logic              en,
  output logic              cpol,
  output logic              cpha,
  output logic [DIV_W-1:0]  div,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              full
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic              en_q, cpol_q, cpha_q, full_q;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] rxbuf_q;
  logic [REG_W-1:0]  rd_mux;
  logic              hit_data, hit_ctrl, hit_stat;
  logic              unused_ctrl_bits;

  assign unused_ctrl_bits = ^wdata[BIT_PHASE-1:BIT_EN+1];

  assign hit_data = (addr == A_DATA);
  assign hit_ctrl = (addr == A_CTRL);
  assign hit_stat = (addr == A_STAT);
  assign start    = wr_en && hit_data && en_q && !busy;
  assign tx_byte  = wdata[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      div_q  <= '0;
    end else if (wr_en && hit_ctrl) begin
      en_q   <= wdata[BIT_EN];
      cpha_q <= wdata[BIT_PHASE];
      cpol_q <= wdata[BIT_IDLE];
      div_q  <= wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      rxbuf_q <= '0;
    end else if (done) begin
      full_q  <= 1'b1;
      rxbuf_q <= rx_word;
    end else if (rd_en && hit_data) begin
      full_q  <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_data) begin
      rd_mux[BYTE_W-1:0] = rxbuf_q;
    end else if (hit_ctrl) begin
      rd_mux[BIT_EN]             = en_q;
      rd_mux[BIT_PHASE]          = cpha_q;
      rd_mux[BIT_IDLE]           = cpol_q;
      rd_mux[DIV_LSB +: DIV_W]   = div_q;
    end else if (hit_stat) begin
      rd_mux[BIT_BUSY] = busy;
      rd_mux[BIT_FULL] = full_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign en   = en_q;
  assign cpol = cpol_q;
  assign cpha = cpha_q;
  assign div  = div_q;
  assign full = full_q;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int REG_W  = spi_host_pkg::REG_W,
  parameter int ADDR_W = spi_host_pkg::ADDR_W,
  parameter int BYTE_W = spi_host_pkg::BYTE_W,
  parameter int DIV_W  = spi_host_pkg::DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_mosi
);
  logic              busy_w, done_w, full_w, en_w, cpol_w, cpha_w, start_w, tick_w;
  logic [DIV_W-1:0]  div_w;
  logic [BYTE_W-1:0] tx_w, rx_w;

  spi_host_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_w), .done(done_w),
    .rx_word(rx_w), .en(en_w), .cpol(cpol_w), .cpha(cpha_w), .div(div_w),
    .start(start_w), .tx_byte(tx_w), .full(full_w)
  );

  spi_host_divider #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst(rst), .run(busy_w && en_w), .div(div_w), .tick(tick_w)
  );

  spi_host_shifter #(.BYTE_W(BYTE_W)) i_shift (
    .clk(clk), .rst(rst), .en(en_w), .cpol(cpol_w), .cpha(cpha_w),
    .start(start_w), .tx_byte(tx_w), .tick(tick_w), .miso(spi_miso),
    .busy(busy_w), .done(done_w), .rx_word(rx_w), .sck(spi_sck), .mosi(spi_mosi)
  );
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              full,
  input logic              done,
  input logic              en,
  input logic              cpol,
  input logic              sck
);
  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && (addr == ADDR_W'(OFS_DATA)) && en));

  // R5
  full_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $fell(busy));

  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(OFS_DATA)) && !done) |=> !full);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !en) |=> !busy);

  // R12
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));
endmodule

bind spi_host_ctrl spi_host_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
  .busy(busy_w), .full(full_w), .done(done_w), .en(en_w), .cpol(cpol_w),
  .sck(spi_sck)
);

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        spi_sck, spi_mosi;
  logic        miso_b;

  int total = 0;
  int bad   = 0;

  // slave model state
  logic       s_cpol = 1'b0, s_cpha = 1'b0, slv_on = 1'b0;
  logic [7:0] s_seed = '0;
  int         arm_cnt = 0;
  logic [7:0] s_sh, s_rx;
  int         tog;

  always #2 clk = ~clk;

  spi_host_ctrl i_spi_host_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_miso(miso_b),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  always @(spi_sck or arm_cnt) begin : slave
    static int seen = 0;
    logic lead;
    if (arm_cnt != seen) begin
      seen   = arm_cnt;
      s_sh   = s_seed;
      s_rx   = '0;
      tog    = 0;
      miso_b = s_cpha ? 1'b0 : s_seed[7];
    end else if (slv_on) begin
      tog  = tog + 1;
      lead = (spi_sck != s_cpol);
      if (lead ^ s_cpha) begin
        s_rx = {s_rx[6:0], spi_mosi};
      end else if (s_cpha) begin
        miso_b = s_sh[7];
        s_sh   = s_sh << 1;
      end else begin
        s_sh   = s_sh << 1;
        miso_b = s_sh[7];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input int mode, input int d, input logic en);
    return 16'((d << 9) | (((mode >> 1) & 1) << 8) | ((mode & 1) << 7) | int'(en));
  endfunction

  task automatic arm(input int mode, input logic [7:0] s);
    s_cpol = mode[1]; s_cpha = mode[0]; s_seed = s;
    arm_cnt++;
    #0;
    slv_on = 1'b1;
  endtask

  task automatic poll_busy(output int ones, output logic [15:0] last);
    ones = 0;
    for (int i = 0; i < 4000; i++) begin
      bus_read(A_STAT, last);
      if (!last[0]) break;
      ones++;
    end
  endtask

  task automatic run_xfer(input int mode, input int d, input logic [7:0] m, input logic [7:0] s);
    int ones;
    logic [15:0] v;
    bus_write(A_CTRL, ctl(mode, d, 1'b1));
    idle(2);
    chk("R12 idle sck", int'(spi_sck), mode >> 1);
    arm(mode, s);
    bus_write(A_DATA, {8'h00, m});
    poll_busy(ones, v);
    slv_on = 1'b0;
    chk("R5 busy length", ones, 16 * (d + 1));
    chk("R5 status at end", int'(v), 2);
    chk("R6 sck toggles", tog, 16);
    chk("R12 sck after", int'(spi_sck), mode >> 1);
    chk("R3 R7 slave got", int'(s_rx), int'(m));
    bus_read(A_DATA, v);
    chk("R4 R7 received", int'(v), int'(s));
    bus_read(A_STAT, v);
    chk("R8 full cleared", int'(v), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int ones;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk("R2 sck", int'(spi_sck), 0);
    chk("R2 mosi", int'(spi_mosi), 0);
    bus_read(A_CTRL, v); chk("R2 ctrl", int'(v), 0);
    bus_read(A_STAT, v); chk("R2 stat", int'(v), 0);
    bus_read(A_DATA, v); chk("R2 data", int'(v), 0);

    // R1 control readback
    bus_write(A_CTRL, 16'hFFFF);
    bus_read(A_CTRL, v); chk("R1 ctrl all ones", int'(v), 16'hFF81);
    bus_write(A_CTRL, 16'h1481);
    bus_read(A_CTRL, v); chk("R1 ctrl pattern", int'(v), 16'h1481);

    // sweep modes, dividers and patterns
    for (int mode = 0; mode < 4; mode++) begin
      for (int di = 0; di < 4; di++) begin
        for (int p = 0; p < 3; p++) begin
          int d;
          logic [7:0] m, s;
          d = (di == 3) ? 6 : di;
          if (p == 0) begin m = 8'h00; s = 8'hFF; end
          else begin
            m = 8'((mode * 61 + di * 23 + p * 101) ^ 8'hA5);
            s = 8'(m * 7 + 13);
          end
          run_xfer(mode, d, m, s);
        end
      end
    end

    // R9 write while busy is ignored
    bus_write(A_CTRL, ctl(0, 1, 1'b1));
    idle(2);
    arm(0, 8'h3C);
    bus_write(A_DATA, 16'h00A5);
    bus_write(A_DATA, 16'h0000);
    poll_busy(ones, v);
    slv_on = 1'b0;
    chk("R9 length kept", ones, 31);
    chk("R9 byte kept", int'(s_rx), 16'hA5);
    bus_read(A_DATA, v); chk("R9 received", int'(v), 16'h3C);

    // R10 write while disabled is ignored
    bus_write(A_CTRL, ctl(0, 0, 1'b0));
    idle(2);
    arm(0, 8'h11);
    bus_write(A_DATA, 16'h0077);
    idle(40);
    slv_on = 1'b0;
    bus_read(A_STAT, v); chk("R10 status", int'(v), 0);
    chk("R10 no toggles", tog, 0);
    bus_read(A_DATA, v); chk("R10 data kept", int'(v), 16'h3C);

    // R11 abort by clearing enable
    bus_write(A_CTRL, ctl(2, 3, 1'b1));
    idle(2);
    arm(2, 8'hFF);
    bus_write(A_DATA, 16'h005A);
    idle(10);
    bus_write(A_CTRL, ctl(2, 3, 1'b0));
    bus_read(A_STAT, v);
    bus_read(A_STAT, v);
    slv_on = 1'b0;
    chk("R11 busy dropped", int'(v), 0);
    chk("R11 sck idle", int'(spi_sck), 1);
    run_xfer(2, 3, 8'hC3, 8'h5E);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule